// File: doc/BRIEF.md
# Shared-Cache Set Victim Picker

This block chooses which way of one 16-way cache set is replaced when a miss arrives. Up to four threads share the set. Every way records a valid bit, the 2-bit identifier of the thread that installed it, and a 4-bit recency age. The block keeps those ages up to date on hits and fills. When a miss is accepted, each thread nominates the oldest block it owns in the set, and an arbiter picks one thread. The block does not evict the oldest block of the whole set. It takes the nomination of the thread that occupies the most of the set. Blocks owned by threads that are no longer running go first.

A cache controller raises `miss_req` with the requesting thread and the mask of running threads. It then reads the chosen way once `victim_vld` rises, writes the new line there, and pulses `fill_req`. Hits from the tag lookup are reported with `hit_req` and `hit_way`. Tag compare and data storage live outside the block.

The controller has three states. ST_IDLE goes to ST_PICK when a miss is accepted. ST_PICK always goes to ST_WAIT_FILL after one cycle, and registers the victim on that edge. ST_WAIT_FILL goes back to ST_IDLE on `fill_req`.

Top module: `set_victim_picker`

## Requirements
- R1: After reset, every way is invalid and `victim_vld` is 0.
- R2: A miss accepted in ST_IDLE at clock edge N gives `victim_vld` = 0 after edge N and `victim_vld` = 1 after edge N+1. The output stays high with a stable `victim_way` until a fill is taken.
- R3: If any way is invalid, the victim is the lowest-numbered invalid way.
- R4: If the set is full and some block belongs to a thread whose bit is 0 in `active_mask` (bit i stands for thread i), the victim is the oldest block among all blocks of such inactive threads.
- R5: Otherwise each thread's count is the number of blocks it owns, plus one for the thread named by `miss_tid`. The thread with the largest count loses its oldest block.
- R6: On an equal count, the thread whose oldest block has the larger age loses.
- R7: A hit on a valid way sets that way's age to 0 (0 is most recent, 15 is least recent). Every valid way that was younger than it ages by one.
- R8: A fill in ST_WAIT_FILL installs the victim way as valid, with thread `miss_tid` from the accepted miss and age 0, and ages the younger valid ways. `victim_vld` is 0 after that edge.
- R9: A hit presented in the same cycle as an accepted fill is ignored.
- R10: A hit sampled on the edge that registers the victim does not affect that victim. A `miss_req` while ST_PICK or ST_WAIT_FILL is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_req | input | 1 | Miss strobe, taken in ST_IDLE |
| miss_tid | input | 2 | Thread that missed |
| active_mask | input | 4 | Bit i set while thread i is running |
| hit_req | input | 1 | Hit strobe |
| hit_way | input | 4 | Way that hit |
| fill_req | input | 1 | Line written into the victim way |
| victim_vld | output | 1 | Victim way is valid |
| victim_way | output | 4 | Way to replace |

## Verification
Recency updates can coincide with the replacement path in two places. A hit can arrive on the very edge where the victim is registered. A hit can also arrive together with the fill. The bench provokes the first case by hitting the block that is about to be chosen while the selection is in flight, and expects the old choice. It provokes the second by hitting the oldest block of one thread during the fill. It then judges the outcome through the next miss, where that thread is made inactive: its oldest block must still be the untouched way.

// File: rtl/vs_pkg.sv
package vs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_PICK      = 2'd1,
        ST_WAIT_FILL = 2'd2
    } vs_state_e;
endpackage

// File: rtl/vs_lru_state.sv
module vs_lru_state #(
    parameter int WAYS    = 16,
    parameter int THREADS = 4,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int TID_W  = $clog2(THREADS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hit_en,
    input  logic [WAY_W-1:0]             hit_way,
    input  logic                         fill_en,
    input  logic [WAY_W-1:0]             fill_way,
    input  logic [TID_W-1:0]             fill_tid,
    output logic [WAYS-1:0]              way_valid,
    output logic [WAYS-1:0][TID_W-1:0]   way_tid,
    output logic [WAYS-1:0][WAY_W-1:0]   way_age
);
    logic             acc_en;
    logic [WAY_W-1:0] acc_way;
    logic [WAY_W-1:0] ref_age;

    // Fill has priority; a hit on an invalid way is dropped.
    assign acc_en  = fill_en | (hit_en & way_valid[hit_way]);
    assign acc_way = fill_en ? fill_way : hit_way;
    assign ref_age = way_valid[acc_way] ? way_age[acc_way] : '1;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                way_valid[g] <= 1'b0;
                way_tid[g]   <= '0;
                way_age[g]   <= '1;
            end else if (acc_en) begin
                if (acc_way == WAY_W'(g)) begin
                    way_age[g] <= '0;
                    if (fill_en) begin
                        way_valid[g] <= 1'b1;
                        way_tid[g]   <= fill_tid;
                    end
                end else if (way_valid[g] && (way_age[g] < ref_age)) begin
                    way_age[g] <= way_age[g] + WAY_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/vs_thread_scan.sv
module vs_thread_scan #(
    parameter int WAYS    = 16,
    parameter int THREADS = 4,
    parameter int TID_ID  = 0,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int TID_W  = $clog2(THREADS),
    localparam int CNT_W  = $clog2(WAYS + 2)
) (
    input  logic [WAYS-1:0]              way_valid,
    input  logic [WAYS-1:0][TID_W-1:0]   way_tid,
    input  logic [WAYS-1:0][WAY_W-1:0]   way_age,
    input  logic [TID_W-1:0]             miss_tid,
    output logic [CNT_W-1:0]             blk_cnt,
    output logic                         has_blk,
    output logic [WAY_W-1:0]             old_way,
    output logic [WAY_W-1:0]             old_age
);
    always_comb begin
        blk_cnt = {{(CNT_W-1){1'b0}}, (miss_tid == TID_W'(TID_ID))};
        has_blk = 1'b0;
        old_way = '0;
        old_age = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_valid[w] && (way_tid[w] == TID_W'(TID_ID))) begin
                blk_cnt = blk_cnt + CNT_W'(1);
                if (!has_blk || (way_age[w] > old_age)) begin
                    old_way = WAY_W'(w);
                    old_age = way_age[w];
                end
                has_blk = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vs_thread_pick.sv
module vs_thread_pick #(
    parameter int WAYS    = 16,
    parameter int THREADS = 4,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int CNT_W  = $clog2(WAYS + 2)
) (
    input  logic [WAYS-1:0]                way_valid,
    input  logic [THREADS-1:0]             active,
    input  logic [THREADS-1:0][CNT_W-1:0]  blk_cnt,
    input  logic [THREADS-1:0]             has_blk,
    input  logic [THREADS-1:0][WAY_W-1:0]  old_way,
    input  logic [THREADS-1:0][WAY_W-1:0]  old_age,
    output logic [WAY_W-1:0]               pick_way
);
    logic             idle_found;
    logic [WAY_W-1:0] idle_way;
    logic             dead_found;
    logic [WAY_W-1:0] dead_way;
    logic [WAY_W-1:0] dead_age;
    logic             big_found;
    logic [WAY_W-1:0] big_way;
    logic [WAY_W-1:0] big_age;
    logic [CNT_W-1:0] big_cnt;

    // Lowest free way, scanned downward so the last hit wins.
    always_comb begin
        idle_found = 1'b0;
        idle_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                idle_found = 1'b1;
                idle_way   = WAY_W'(w);
            end
        end
    end

    always_comb begin
        dead_found = 1'b0;
        dead_way   = '0;
        dead_age   = '0;
        big_found  = 1'b0;
        big_way    = '0;
        big_age    = '0;
        big_cnt    = '0;
        for (int t = 0; t < THREADS; t++) begin
            if (has_blk[t] && !active[t]) begin
                if (!dead_found || (old_age[t] > dead_age)) begin
                    dead_way = old_way[t];
                    dead_age = old_age[t];
                end
                dead_found = 1'b1;
            end
            if (has_blk[t]) begin
                if (!big_found || (blk_cnt[t] > big_cnt) ||
                    ((blk_cnt[t] == big_cnt) && (old_age[t] > big_age))) begin
                    big_way = old_way[t];
                    big_age = old_age[t];
                    big_cnt = blk_cnt[t];
                end
                big_found = 1'b1;
            end
        end
    end

    always_comb begin
        if (idle_found)      pick_way = idle_way;
        else if (dead_found) pick_way = dead_way;
        else                 pick_way = big_way;
    end
endmodule

// File: rtl/set_victim_picker.sv
module set_victim_picker
    import vs_pkg::*;
#(
    parameter int WAYS    = 16,
    parameter int THREADS = 4,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int TID_W  = $clog2(THREADS),
    localparam int CNT_W  = $clog2(WAYS + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_req,
    input  logic [TID_W-1:0]   miss_tid,
    input  logic [THREADS-1:0] active_mask,
    input  logic               hit_req,
    input  logic [WAY_W-1:0]   hit_way,
    input  logic               fill_req,
    output logic               victim_vld,
    output logic [WAY_W-1:0]   victim_way
);
    vs_state_e          state;
    logic [TID_W-1:0]   lat_tid;
    logic [THREADS-1:0] lat_mask;
    logic               fill_en;
    logic               hit_en;
    logic [WAY_W-1:0]   pick_way;

    logic [WAYS-1:0]              way_valid;
    logic [WAYS-1:0][TID_W-1:0]   way_tid;
    logic [WAYS-1:0][WAY_W-1:0]   way_age;

    logic [THREADS-1:0][CNT_W-1:0] blk_cnt;
    logic [THREADS-1:0]            has_blk;
    logic [THREADS-1:0][WAY_W-1:0] old_way;
    logic [THREADS-1:0][WAY_W-1:0] old_age;

    assign fill_en = (state == ST_WAIT_FILL) && fill_req;
    assign hit_en  = hit_req && !fill_en;

    // State register and miss capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lat_tid  <= '0;
            lat_mask <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (miss_req) begin
                        state    <= ST_PICK;
                        lat_tid  <= miss_tid;
                        lat_mask <= active_mask;
                    end
                end
                ST_PICK:      state <= ST_WAIT_FILL;
                ST_WAIT_FILL: if (fill_req) state <= ST_IDLE;
                default:      state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_vld <= 1'b0;
            victim_way <= '0;
        end else begin
            unique case (state)
                ST_PICK: begin
                    victim_vld <= 1'b1;
                    victim_way <= pick_way;
                end
                ST_WAIT_FILL: if (fill_req) victim_vld <= 1'b0;
                default:      victim_vld <= 1'b0;
            endcase
        end
    end

    vs_lru_state #(.WAYS(WAYS), .THREADS(THREADS)) i_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_en    (hit_en),
        .hit_way   (hit_way),
        .fill_en   (fill_en),
        .fill_way  (victim_way),
        .fill_tid  (lat_tid),
        .way_valid (way_valid),
        .way_tid   (way_tid),
        .way_age   (way_age)
    );

    for (genvar t = 0; t < THREADS; t++) begin : g_scan
        vs_thread_scan #(.WAYS(WAYS), .THREADS(THREADS), .TID_ID(t)) i_scan (
            .way_valid (way_valid),
            .way_tid   (way_tid),
            .way_age   (way_age),
            .miss_tid  (lat_tid),
            .blk_cnt   (blk_cnt[t]),
            .has_blk   (has_blk[t]),
            .old_way   (old_way[t]),
            .old_age   (old_age[t])
        );
    end

    vs_thread_pick #(.WAYS(WAYS), .THREADS(THREADS)) i_pick (
        .way_valid (way_valid),
        .active    (lat_mask),
        .blk_cnt   (blk_cnt),
        .has_blk   (has_blk),
        .old_way   (old_way),
        .old_age   (old_age),
        .pick_way  (pick_way)
    );
endmodule

// File: rtl/set_victim_picker_chk.sv
module set_victim_picker_chk #(
    parameter int WAYS   = 16,
    localparam int WAY_W = $clog2(WAYS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             miss_req,
    input logic             fill_req,
    input logic             victim_vld,
    input logic [WAY_W-1:0] victim_way,
    input logic [WAYS-1:0]  way_valid
);
    AST_VLD_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(victim_vld) |-> $past(miss_req, 2)); // R2
    AST_VLD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_vld && !fill_req) |=> (victim_vld && $stable(victim_way))); // R2
    AST_FREE_WAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_vld && !(&way_valid)) |-> !way_valid[victim_way]); // R3
    AST_FILL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_vld && fill_req) |=> !victim_vld); // R8
    AST_FILL_INSTALL: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_vld && fill_req) |=> way_valid[$past(victim_way)]); // R8
endmodule

bind set_victim_picker set_victim_picker_chk #(.WAYS(WAYS)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_req   (miss_req),
    .fill_req   (fill_req),
    .victim_vld (victim_vld),
    .victim_way (victim_way),
    .way_valid  (way_valid)
);

// File: tb/test_set_victim_picker.sv
module test_set_victim_picker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       miss_req = 1'b0;
    logic [1:0] miss_tid = '0;
    logic [3:0] active_mask = '0;
    logic       hit_req = 1'b0;
    logic [3:0] hit_way = '0;
    logic       fill_req = 1'b0;
    logic       victim_vld;
    logic [3:0] victim_way;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    set_victim_picker i_set_victim_picker (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss_req    (miss_req),
        .miss_tid    (miss_tid),
        .active_mask (active_mask),
        .hit_req     (hit_req),
        .hit_way     (hit_way),
        .fill_req    (fill_req),
        .victim_vld  (victim_vld),
        .victim_way  (victim_way)
    );

    // {miss thread, expected way}; all threads active. Entries 0..15 fill an
    // empty set (R3), 16 is a plain largest-count pick (R5), 17 a tie (R6).
    localparam logic [5:0] VEC [18] = '{
        {2'd0, 4'd0},  {2'd0, 4'd1},  {2'd0, 4'd2},  {2'd0, 4'd3},
        {2'd0, 4'd4},  {2'd0, 4'd5},  {2'd0, 4'd6},  {2'd1, 4'd7},
        {2'd1, 4'd8},  {2'd1, 4'd9},  {2'd1, 4'd10}, {2'd2, 4'd11},
        {2'd2, 4'd12}, {2'd2, 4'd13}, {2'd3, 4'd14}, {2'd3, 4'd15},
        {2'd1, 4'd0},  {2'd1, 4'd1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_miss(input logic [1:0] tid, input logic [3:0] mask,
                           input bit pick_hit, input logic [3:0] hw,
                           input int exp_way, input string req);
        @(negedge clk);
        miss_req = 1'b1; miss_tid = tid; active_mask = mask;
        @(negedge clk);
        miss_req = 1'b0;
        if (pick_hit) begin hit_req = 1'b1; hit_way = hw; end
        check(victim_vld == 1'b0, "R2", int'(victim_vld), 0);
        @(negedge clk);
        hit_req = 1'b0;
        check(victim_vld == 1'b1, "R2", int'(victim_vld), 1);
        check(int'(victim_way) == exp_way, req, int'(victim_way), exp_way);
    endtask

    task automatic do_fill(input bit with_hit, input logic [3:0] hw);
        @(negedge clk);
        fill_req = 1'b1;
        if (with_hit) begin hit_req = 1'b1; hit_way = hw; end
        @(negedge clk);
        fill_req = 1'b0; hit_req = 1'b0;
        check(victim_vld == 1'b0, "R8", int'(victim_vld), 0);
    endtask

    task automatic do_hit(input logic [3:0] hw);
        @(negedge clk);
        hit_req = 1'b1; hit_way = hw;
        @(negedge clk);
        hit_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(victim_vld == 1'b0, "R1", int'(victim_vld), 0);

        // Table walk: fills leave way i at age 15-i, then counted picks.
        for (int i = 0; i < 18; i++) begin
            do_miss(VEC[i][5:4], 4'hF, 1'b0, 4'd0, int'(VEC[i][3:0]),
                    (i < 16) ? "R3" : ((i == 16) ? "R5" : "R6"));
            do_fill(1'b0, 4'd0);
        end

        // R7: refresh ways 2..6 of thread 0 so thread 1's oldest becomes oldest.
        for (int w = 2; w <= 6; w++) do_hit(4'(w));
        // R6/R7: counts tie at 6 (thread 0 gets +1 for the miss); way 7 is older.
        do_miss(2'd0, 4'hF, 1'b0, 4'd0, 7, "R7");
        do_fill(1'b0, 4'd0);

        // R4 with R10: thread 3 inactive, oldest of its ways is 14; a hit on 14
        // at the selection edge must not move the choice to way 15.
        do_miss(2'd0, 4'b0111, 1'b1, 4'd14, 14, "R4");
        // R10: a miss while waiting for the fill is ignored.
        @(negedge clk);
        miss_req = 1'b1; miss_tid = 2'd3; active_mask = 4'hF;
        @(negedge clk);
        miss_req = 1'b0;
        @(negedge clk);
        check(victim_vld == 1'b1, "R10", int'(victim_vld), 1);
        check(victim_way == 4'd14, "R10", int'(victim_way), 14);
        // R9: hit on way 8 (oldest of thread 1) together with the fill.
        do_fill(1'b1, 4'd8);
        // R9: thread 1 inactive; way 8 must still be its oldest block.
        do_miss(2'd3, 4'b1101, 1'b0, 4'd0, 8, "R9");
        do_fill(1'b0, 4'd0);

        // R8: back in idle, a new miss is accepted and counted normally.
        // Thread 0 owns 2..7,14 (7 blocks); its oldest is way 2.
        do_miss(2'd1, 4'hF, 1'b0, 4'd0, 2, "R8");
        do_fill(1'b0, 4'd0);

        finish_run();
    end
endmodule